// File: doc/BRIEF.md
# Float-to-Integer Converter with Selectable Out-of-Range Policy

This block turns a binary64 floating-point operand into a 32-bit or 64-bit integer, signed or unsigned, and always returns a 64-bit result. Optionally, the operand is first narrowed to binary32 precision. A 3-bit policy code selects two things. The first is where the rounding direction comes from: the 2-bit rounding-mode input, or forced truncation toward zero. The second is how NaN, infinity and out-of-range values are handled. The choices are saturation with NaN mapped to the type minimum, saturation with NaN mapped to zero, or modulo-2^N wrapping with NaN and infinity mapped to zero.

Alongside the integer, the block reports the following:
- signalling-NaN and invalid-conversion flags;
- an inexact flag and a rounded-up flag;
- an integer-overflow indication for the fixed-point exception register, raised when overflow reporting is requested and the integer does not exactly represent the source;
- an illegal-code indication.

A write enable tells the register file whether the destination may be written. It is dropped for illegal codes, and for invalid operations while invalid-operation trapping is enabled. A result appears one clock after the operand is presented.

Top module: `fp_to_int_cvt`

## Requirements
- R1: `out_valid` is low during and after reset until an operand arrives, and each operand presented with `in_valid` high produces `out_valid` and its result exactly one clock later.
- R2: In-range values return the correctly rounded integer. The rounding direction follows `round_mode`: 00 nearest-even, 01 toward zero, 10 toward +infinity, 11 toward -infinity. It does so only when bit 0 of `cvt_mode` is 0; when that bit is 1, truncation is used regardless of `round_mode`.
- R3: `cvt_mode` 000/001: NaN returns the minimum of the target type, and values above or below the type range saturate to its maximum or minimum.
- R4: `cvt_mode` 010/011: NaN returns 0, and values outside the type range saturate to its maximum or minimum.
- R5: `cvt_mode` 100/101: NaN and infinities return 0, and rounded magnitudes of 2^128 or more return 0. Other values have their rounded two's-complement value reduced modulo 2^32 or 2^64 and reinterpreted as the target type.
- R6: `int_kind` selects the target type: 0 signed 32-bit, 1 unsigned 32-bit, 2 signed 64-bit, 3 unsigned 64-bit. A signed 32-bit result is sign-extended to 64 bits, and an unsigned 32-bit result is zero-extended.
- R7: `cvt_mode` 110 and 111 raise `illegal`, hold `write_en` low, and return a zero result with every flag clear.
- R8: `flag_snan` is raised for a NaN whose fraction bit 51 is 0. `flag_cvi` is raised for any NaN in any legal mode, and for a saturated result in modes 000 to 011.
- R9: `flag_inexact` is raised when a converted (not saturated, not zeroed) value had a nonzero fraction. `flag_round_up` is raised when rounding increased the magnitude.
- R10: `overflow` is raised only when `oe_en` is 1, and then whenever the source is NaN or the returned integer differs from the source value.
- R11: When `inv_enable` is 1 and `flag_snan` or `flag_cvi` is raised, `write_en` is low, the result is 0, and `flag_inexact` and `flag_round_up` are clear. Otherwise a legal conversion has `write_en` high.
- R12: With `single_src` high, the low 29 fraction bits of the binary64 operand are discarded before conversion, so the value converted is the binary32-precision one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand and controls are valid this cycle |
| src_bits | input | 64 | binary64 source operand |
| single_src | input | 1 | Narrow the operand to binary32 precision first |
| int_kind | input | 2 | Target integer type |
| cvt_mode | input | 3 | Rounding-source and out-of-range policy code |
| round_mode | input | 2 | Rounding direction from the status register |
| oe_en | input | 1 | Report integer overflow |
| inv_enable | input | 1 | Invalid-operation trapping enabled |
| out_valid | output | 1 | Result valid |
| write_en | output | 1 | Destination may be written |
| result | output | 64 | Integer result, extended to 64 bits |
| illegal | output | 1 | Illegal policy code |
| flag_snan | output | 1 | Signalling-NaN invalid flag |
| flag_cvi | output | 1 | Invalid-conversion flag |
| flag_inexact | output | 1 | Fraction was lost |
| flag_round_up | output | 1 | Magnitude was incremented by rounding |
| overflow | output | 1 | Integer overflow indication |

## Verification
Every output is due on the clock edge after the one that captures the operand, so all results are valid one full cycle after `in_valid`. The bench drives operands on falling edges and stamps each expected entry with the count of rising edges seen so far. The monitor compares results on falling edges and requires the stamp to be exactly one less than the current count, so a result that is late or early counts as a failure even when its value is correct. Back-to-back operands with no idle cycles confirm that each result is tied to the operand before it.

// File: rtl/fp_to_int_cvt.sv
module fp_to_int_cvt (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] src_bits,
  input  logic        single_src,
  input  logic [1:0]  int_kind,
  input  logic [2:0]  cvt_mode,
  input  logic [1:0]  round_mode,
  input  logic        oe_en,
  input  logic        inv_enable,
  output logic        out_valid,
  output logic        write_en,
  output logic [63:0] result,
  output logic        illegal,
  output logic        flag_snan,
  output logic        flag_cvi,
  output logic        flag_inexact,
  output logic        flag_round_up,
  output logic        overflow
);

  // operand decode
  logic        sign;
  logic [10:0] expf;
  logic [51:0] frac;
  logic        top_exp, is_nan, is_inf, is_snan;
  logic [52:0] mant;
  logic signed [12:0] e;
  logic [6:0]  rsh;
  logic        huge, tiny;

  assign sign    = src_bits[63];
  assign expf    = src_bits[62:52];
  assign frac    = single_src ? {src_bits[51:29], 29'b0} : src_bits[51:0];
  assign top_exp = &expf;
  assign is_nan  = top_exp & (|frac);
  assign is_inf  = top_exp & ~(|frac);
  assign is_snan = is_nan & ~frac[51];
  assign mant    = {|expf, frac};
  assign e       = (expf == 11'd0) ? -13'sd1022 : $signed({2'b00, expf}) - 13'sd1023;
  assign rsh     = 7'(13'sd0 - e);
  assign huge    = top_exp | (!e[12] && (|e[11:7]));
  assign tiny    = e < -13'sd76;

  // alignment: bit 128 of the field is the units position
  logic [255:0] base, aligned;
  logic [127:0] ipart;
  logic         rbit, sticky;

  assign base = {127'b0, mant, 76'b0};

  always_comb begin
    if (tiny)        aligned = '0;
    else if (!e[12]) aligned = base << e[6:0];
    else             aligned = base >> rsh;
  end

  assign ipart  = aligned[255:128];
  assign rbit   = aligned[127];
  assign sticky = tiny ? (|mant) : (|aligned[126:0]);

  // rounding
  logic [1:0]   rm_eff;
  logic         inc;
  logic [128:0] mag;

  assign rm_eff = cvt_mode[0] ? 2'b01 : round_mode;

  always_comb begin
    case (rm_eff)
      2'b00:   inc = rbit & (sticky | ipart[0]);
      2'b01:   inc = 1'b0;
      2'b10:   inc = ~sign & (rbit | sticky);
      default: inc = sign & (rbit | sticky);
    endcase
  end

  assign mag = {1'b0, ipart} + {128'b0, inc};

  // type limits
  logic [128:0] pos_lim, neg_lim;
  logic [63:0]  max_val, min_val;

  always_comb begin
    case (int_kind)
      2'd0: begin
        pos_lim = 129'h7FFF_FFFF;          neg_lim = 129'h8000_0000;
        max_val = 64'h0000_0000_7FFF_FFFF; min_val = 64'hFFFF_FFFF_8000_0000;
      end
      2'd1: begin
        pos_lim = 129'hFFFF_FFFF;          neg_lim = '0;
        max_val = 64'h0000_0000_FFFF_FFFF; min_val = '0;
      end
      2'd2: begin
        pos_lim = 129'h7FFF_FFFF_FFFF_FFFF; neg_lim = 129'h8000_0000_0000_0000;
        max_val = 64'h7FFF_FFFF_FFFF_FFFF;  min_val = 64'h8000_0000_0000_0000;
      end
      default: begin
        pos_lim = 129'hFFFF_FFFF_FFFF_FFFF; neg_lim = '0;
        max_val = 64'hFFFF_FFFF_FFFF_FFFF;  min_val = '0;
      end
    endcase
  end

  logic over_hi, under_lo, wrap_zero, sat_mode, bad_code;
  assign over_hi   = !is_nan & !sign & (is_inf | huge | (mag > pos_lim));
  assign under_lo  = !is_nan &  sign & (is_inf | huge | (mag > neg_lim));
  assign wrap_zero = is_nan | is_inf | huge | mag[128];
  assign sat_mode  = ~cvt_mode[2];
  assign bad_code  = cvt_mode[2] & cvt_mode[1];

  // result assembly
  logic [63:0] val64, ext64, res_c;

  assign val64 = sign ? (64'd0 - mag[63:0]) : mag[63:0];

  always_comb begin
    case (int_kind)
      2'd0:    ext64 = {{32{val64[31]}}, val64[31:0]};
      2'd1:    ext64 = {32'b0, val64[31:0]};
      default: ext64 = val64;
    endcase
  end

  always_comb begin
    if (bad_code)       res_c = '0;
    else if (sat_mode) begin
      if (is_nan)       res_c = cvt_mode[1] ? 64'd0 : min_val;
      else if (over_hi) res_c = max_val;
      else if (under_lo) res_c = min_val;
      else              res_c = ext64;
    end
    else if (wrap_zero) res_c = '0;
    else                res_c = ext64;
  end

  // flags
  logic clean, exact, snan_c, cvi_c, blocked, we_c;
  assign clean   = sat_mode ? !(is_nan | over_hi | under_lo) : !wrap_zero;
  assign exact   = !is_nan & !is_inf & !huge & !over_hi & !under_lo & !(rbit | sticky);
  assign snan_c  = !bad_code & is_snan;
  assign cvi_c   = !bad_code & (is_nan | (sat_mode & (over_hi | under_lo)));
  assign blocked = inv_enable & (snan_c | cvi_c);
  assign we_c    = !bad_code & !blocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      write_en      <= 1'b0;
      result        <= '0;
      illegal       <= 1'b0;
      flag_snan     <= 1'b0;
      flag_cvi      <= 1'b0;
      flag_inexact  <= 1'b0;
      flag_round_up <= 1'b0;
      overflow      <= 1'b0;
    end else begin
      out_valid     <= in_valid;
      write_en      <= in_valid & we_c;
      result        <= we_c ? res_c : 64'd0;
      illegal       <= bad_code;
      flag_snan     <= snan_c;
      flag_cvi      <= cvi_c;
      flag_inexact  <= we_c & clean & (rbit | sticky);
      flag_round_up <= we_c & clean & inc;
      overflow      <= !bad_code & oe_en & !exact;
    end
  end

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid) |-> out_valid); // R1
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && illegal |-> !write_en && result == 64'd0 && !flag_cvi); // R7
  AST_S32_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(int_kind) == 2'd0 |-> result[63:32] == {32{result[31]}}); // R6
  AST_U32_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(int_kind) == 2'd1 |-> result[63:32] == 32'd0); // R6
  AST_SNAN_IS_CVI: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flag_snan |-> flag_cvi); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !$past(oe_en) |-> !overflow); // R10
  AST_INV_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(inv_enable) && (flag_cvi || flag_snan)
      |-> !write_en && !flag_inexact && !flag_round_up); // R11

endmodule

// File: tb/fp_to_int_cvt_bench.sv
module fp_to_int_cvt_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [63:0] src_bits = '0;
  logic single_src = 1'b0;
  logic [1:0] int_kind = '0;
  logic [2:0] cvt_mode = '0;
  logic [1:0] round_mode = '0;
  logic oe_en = 1'b0;
  logic inv_enable = 1'b0;
  logic out_valid, write_en, illegal, flag_snan, flag_cvi, flag_inexact, flag_round_up, overflow;
  logic [63:0] result;

  always #4 clk = ~clk;

  fp_to_int_cvt u_fp_to_int_cvt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_bits(src_bits),
    .single_src(single_src), .int_kind(int_kind), .cvt_mode(cvt_mode),
    .round_mode(round_mode), .oe_en(oe_en), .inv_enable(inv_enable),
    .out_valid(out_valid), .write_en(write_en), .result(result), .illegal(illegal),
    .flag_snan(flag_snan), .flag_cvi(flag_cvi), .flag_inexact(flag_inexact),
    .flag_round_up(flag_round_up), .overflow(overflow)
  );

  typedef struct packed {
    logic [63:0] res;
    logic we, ill, sn, cv, fi, fr, ov;
  } exp_t;

  exp_t  exp_q[$];
  int    cyc_q[$];
  string tag_q[$];
  int    cyc = 0;
  int    total = 0;
  int    passed = 0;
  bit    finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  localparam logic [63:0] P1_0  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] M1_0  = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] P2_5  = 64'h4004_0000_0000_0000;
  localparam logic [63:0] M2_5  = 64'hC004_0000_0000_0000;
  localparam logic [63:0] P3_5  = 64'h400C_0000_0000_0000;
  localparam logic [63:0] P1_5  = 64'h3FF8_0000_0000_0000;
  localparam logic [63:0] M0_5  = 64'hBFE0_0000_0000_0000;
  localparam logic [63:0] QNAN  = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] SNAN  = 64'h7FF4_0000_0000_0000;
  localparam logic [63:0] PINF  = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] MINF  = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] P3E9  = 64'h41E6_5A0B_C000_0000;
  localparam logic [63:0] M2P31 = 64'hC1E0_0000_0000_0000;
  localparam logic [63:0] M2P31M1 = 64'hC1E0_0000_0020_0000;
  localparam logic [63:0] P2P32P5 = 64'h41F0_0000_0050_0000;
  localparam logic [63:0] P2P128  = 64'h47F0_0000_0000_0000;
  localparam logic [63:0] P2P64P12 = 64'h43F0_0000_0000_0001;
  localparam logic [63:0] DENORM  = 64'h0000_0000_0000_0001;
  localparam logic [63:0] ONE_EPS = 64'h3FF0_0000_0000_1000;

  task automatic check(input bit ok, input string what, input string act, input string expv);
    total++;
    if (ok) passed++;
    else $display("FAIL %s actual=%s expected=%s", what, act, expv);
  endtask

  task automatic drive(input logic [63:0] s, input bit sg, input logic [1:0] k,
                       input logic [2:0] m, input logic [1:0] rm, input bit oe, input bit inv,
                       input logic [63:0] er, input bit ewe, input bit eill, input bit esn,
                       input bit ecv, input bit efi, input bit efr, input bit eov, input string tag);
    exp_t x;
    @(negedge clk);
    in_valid = 1'b1; src_bits = s; single_src = sg; int_kind = k; cvt_mode = m;
    round_mode = rm; oe_en = oe; inv_enable = inv;
    x.res = er; x.we = ewe; x.ill = eill; x.sn = esn; x.cv = ecv; x.fi = efi; x.fr = efr; x.ov = eov;
    exp_q.push_back(x);
    cyc_q.push_back(cyc);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 unexpected out_valid", "1", "0");
      end else begin
        exp_t x;
        int c;
        string t;
        x = exp_q.pop_front();
        c = cyc_q.pop_front();
        t = tag_q.pop_front();
        check(cyc == c + 1, {"R1 latency ", t}, $sformatf("%0d", cyc - c), "1");
        check({result, write_en, illegal, flag_snan, flag_cvi, flag_inexact, flag_round_up, overflow} == x, t,
              $sformatf("res=%h we%0b ill%0b sn%0b cv%0b fi%0b fr%0b ov%0b", result, write_en, illegal,
                        flag_snan, flag_cvi, flag_inexact, flag_round_up, overflow),
              $sformatf("res=%h we%0b ill%0b sn%0b cv%0b fi%0b fr%0b ov%0b", x.res, x.we, x.ill,
                        x.sn, x.cv, x.fi, x.fr, x.ov));
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1 reset out_valid", $sformatf("%0b", out_valid), "0");
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 idle after reset", $sformatf("%0b", out_valid), "0");

    // R2 rounding directions
    drive(P2_5, 0, 2, 3'b000, 2'b00, 0, 0, 64'd2, 1,0,0,0,1,0,0, "R2 2.5 nearest-even");
    drive(P2_5, 0, 2, 3'b000, 2'b10, 0, 0, 64'd3, 1,0,0,0,1,1,0, "R2 2.5 ceil");
    drive(M2_5, 0, 2, 3'b000, 2'b11, 0, 0, 64'hFFFF_FFFF_FFFF_FFFD, 1,0,0,0,1,1,0, "R2 -2.5 floor");
    drive(M2_5, 0, 2, 3'b000, 2'b00, 0, 0, 64'hFFFF_FFFF_FFFF_FFFE, 1,0,0,0,1,0,0, "R2 -2.5 nearest");
    drive(P3_5, 0, 0, 3'b010, 2'b00, 0, 0, 64'd4, 1,0,0,0,1,1,0, "R2 3.5 nearest");
    drive(P1_5, 0, 2, 3'b001, 2'b00, 0, 0, 64'd1, 1,0,0,0,1,0,0, "R2 forced truncation");
    // R3 NaN to minimum, saturation
    drive(QNAN, 0, 0, 3'b000, 2'b00, 0, 0, 64'hFFFF_FFFF_8000_0000, 1,0,0,1,0,0,0, "R3 NaN s32");
    drive(QNAN, 0, 2, 3'b001, 2'b00, 0, 0, 64'h8000_0000_0000_0000, 1,0,0,1,0,0,0, "R3 NaN s64");
    drive(SNAN, 0, 3, 3'b000, 2'b00, 0, 0, 64'd0, 1,0,1,1,0,0,0, "R8 sNaN u64");
    drive(P3E9, 0, 0, 3'b000, 2'b00, 0, 0, 64'h0000_0000_7FFF_FFFF, 1,0,0,1,0,0,0, "R3 sat high s32");
    drive(M2P31M1, 0, 0, 3'b001, 2'b00, 0, 0, 64'hFFFF_FFFF_8000_0000, 1,0,0,1,0,0,0, "R3 sat low s32");
    // R6 extension
    drive(M2P31, 0, 0, 3'b000, 2'b00, 0, 0, 64'hFFFF_FFFF_8000_0000, 1,0,0,0,0,0,0, "R6 s32 min exact");
    drive(P3E9, 0, 1, 3'b000, 2'b00, 0, 0, 64'h0000_0000_B2D0_5E00, 1,0,0,0,0,0,0, "R6 u32 zext");
    // R4 NaN to zero, saturation
    drive(QNAN, 0, 0, 3'b010, 2'b00, 0, 0, 64'd0, 1,0,0,1,0,0,0, "R4 NaN zero");
    drive(PINF, 0, 2, 3'b011, 2'b00, 0, 0, 64'h7FFF_FFFF_FFFF_FFFF, 1,0,0,1,0,0,0, "R4 +Inf sat");
    drive(M1_0, 0, 1, 3'b010, 2'b00, 0, 0, 64'd0, 1,0,0,1,0,0,0, "R4 negative u32");
    drive(P2P128, 0, 3, 3'b010, 2'b00, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 1,0,0,1,0,0,0, "R4 2^128 u64");
    // R5 wrapping
    drive(P2P32P5, 0, 0, 3'b100, 2'b00, 0, 0, 64'd5, 1,0,0,0,0,0,0, "R5 wrap 2^32+5");
    drive(P3E9, 0, 0, 3'b101, 2'b00, 0, 0, 64'hFFFF_FFFF_B2D0_5E00, 1,0,0,0,0,0,0, "R5 wrap 3e9 s32");
    drive(MINF, 0, 2, 3'b100, 2'b00, 0, 0, 64'd0, 1,0,0,0,0,0,0, "R5 -Inf zero");
    drive(QNAN, 0, 2, 3'b101, 2'b00, 0, 0, 64'd0, 1,0,0,1,0,0,0, "R5 NaN zero");
    drive(P2P128, 0, 3, 3'b100, 2'b00, 0, 0, 64'd0, 1,0,0,0,0,0,0, "R5 2^128 zero");
    drive(P2P64P12, 0, 3, 3'b100, 2'b00, 0, 0, 64'h1000, 1,0,0,0,0,0,0, "R5 wrap 2^64+2^12");
    // R7 illegal codes
    drive(P1_0, 0, 2, 3'b110, 2'b00, 1, 0, 64'd0, 0,1,0,0,0,0,0, "R7 code 110");
    drive(QNAN, 0, 2, 3'b111, 2'b00, 1, 1, 64'd0, 0,1,0,0,0,0,0, "R7 code 111");
    // R9 inexact and round-up
    drive(DENORM, 0, 1, 3'b000, 2'b10, 0, 0, 64'd1, 1,0,0,0,1,1,0, "R9 denormal ceil");
    drive(M0_5, 0, 1, 3'b001, 2'b00, 0, 0, 64'd0, 1,0,0,0,1,0,0, "R9 -0.5 u32 trunc");
    // R10 overflow
    drive(P2_5, 0, 2, 3'b001, 2'b00, 1, 0, 64'd2, 1,0,0,0,1,0,1, "R10 inexact overflow");
    drive(P1_0, 0, 2, 3'b000, 2'b00, 1, 0, 64'd1, 1,0,0,0,0,0,0, "R10 exact no overflow");
    drive(QNAN, 0, 2, 3'b010, 2'b00, 1, 0, 64'd0, 1,0,0,1,0,0,1, "R10 NaN overflow");
    drive(P3E9, 0, 0, 3'b100, 2'b00, 1, 0, 64'hFFFF_FFFF_B2D0_5E00, 1,0,0,0,0,0,1, "R10 wrap overflow");
    // R11 invalid enable
    drive(QNAN, 0, 2, 3'b000, 2'b00, 0, 1, 64'd0, 0,0,0,1,0,0,0, "R11 NaN blocked");
    drive(P2_5, 0, 2, 3'b001, 2'b00, 0, 1, 64'd2, 1,0,0,0,1,0,0, "R11 valid still written");
    drive(P3E9, 0, 0, 3'b000, 2'b10, 0, 1, 64'd0, 0,0,0,1,0,0,0, "R11 saturation blocked");
    // R12 single-source narrowing
    drive(ONE_EPS, 0, 2, 3'b000, 2'b10, 0, 0, 64'd2, 1,0,0,0,1,1,0, "R12 double ceil");
    drive(ONE_EPS, 1, 2, 3'b000, 2'b10, 1, 0, 64'd1, 1,0,0,0,0,0,0, "R12 single exact");

    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R1 all results delivered", $sformatf("%0d", exp_q.size()), "0");
    finished = 1'b1;
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", passed, total);
      $finish;
    end
  end

endmodule